// File: doc/BRIEF.md
# GPIO Interrupt Summary Aggregator

This block sits between a large array of per-pin interrupt detectors and a single processor interrupt input. Each detector drives one bit of a pending vector. The block folds the vector into a summary in which each bit stands for a run of four neighbouring pins. It registers the summary once and presents it to software as two 32-bit read-only status words that together form one 64-bit value. With the default 184 pins there are 46 valid summary bits, and every bit above them reads as zero.

The block drives one interrupt line that the processor may share with other sources. The line is a sticky request. It is set when any valid summary bit is set while the global enable is on. It stays set until software writes the end-of-interrupt bit in the master control word. If any pin is still pending after that write, the line comes back on the next clock, so no event is lost between the handler's last scan and its acknowledge. The end-of-interrupt bit clears itself, so the usual read-modify-write of the master word leaves the enable unchanged.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit n is 1 exactly when at least one of pins 4n, 4n+1, 4n+2, 4n+3 is pending. A change on the pending inputs shows in the status words one clock later.
- R2: Address 0 reads summary bits 31:0. Address 1 reads summary bits 63:32, so summary bit 45 appears at bit 13 of address 1.
- R3: Summary bits 46 to 63 always read as 0, which at address 1 means bits 31:14.
- R4: Writes to addresses 0 and 1 change nothing. Both status words are read-only.
- R5: Address 2 is the master word. Bit 0 is the global interrupt enable and is read/write. Bit 1 is the end-of-interrupt bit and always reads 0. All other bits read 0. Address 3 reads 0.
- R6: With the enable at 1, the line rises two clocks after a pin becomes pending: one clock to register the summary and one to set the line. It rises only if some summary bit was set in the cycle before.
- R7: Once high, the line stays high after all pins stop pending, until an end-of-interrupt write is made or the enable is cleared.
- R8: A write to address 2 with bit 1 set drops the line on the next clock. If a summary bit is still set, the line rises again one clock later. The acknowledge wins over a pending arrival in the same cycle.
- R9: While the enable reads 0, the line goes low within one clock and is not set. After the enable returns to 1, a pending summary sets the line again.
- R10: After reset the line is low, both status words read 0 and the master word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_pend_i | input | 184 | Pending flag from each pin detector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Shared interrupt request to the processor |

## Verification
Two events can fall in the same cycle: the end-of-interrupt write and a new pending pin. The line must not be lost or stuck when they coincide. The bench provokes this by raising a fresh pin at the same falling edge on which it drives an acknowledge write. It then expects the line to read low one cycle later and high the cycle after that. A second case pairs an acknowledge with a pin that never stopped pending, and expects the same low-then-high pattern.

// File: rtl/gpio_sum_pkg.sv
// Package: shared register addresses and master-word bit positions for the
// GPIO interrupt summary aggregator. Assumes a two-bit word address.
package gpio_sum_pkg;
    localparam logic [1:0] ADDR_SUM_LO = 2'd0;
    localparam logic [1:0] ADDR_SUM_HI = 2'd1;
    localparam logic [1:0] ADDR_MASTER = 2'd2;
    localparam int MST_EN_BIT  = 0;
    localparam int MST_EOI_BIT = 1;
endpackage

// File: rtl/gpio_sum_fold.sv
// Module: folds the per-pin pending vector into one bit per group of GROUP
// pins and registers the result once. Pins past NUM_PINS in the last group
// are treated as idle. Assumes pending inputs are already synchronous.
module gpio_sum_fold #(
    parameter int NUM_PINS = 184,
    parameter int GROUP    = 4,
    parameter int SUM_BITS = (NUM_PINS + GROUP - 1) / GROUP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pend_i,
    output logic [SUM_BITS-1:0] sum_o,
    output logic                any_o
);
    localparam int PAD_W = SUM_BITS * GROUP;

    logic [PAD_W-1:0]    pend_pad;
    logic [SUM_BITS-1:0] grp_or;
    logic [SUM_BITS-1:0] sum_q;

    // Zero-extend the pending vector to a whole number of groups.
    always_comb begin
        pend_pad = '0;
        pend_pad[NUM_PINS-1:0] = pend_i;
    end

    // One OR-reduction per summary bit.
    for (genvar g = 0; g < SUM_BITS; g++) begin : g_group
        assign grp_or[g] = |pend_pad[g*GROUP +: GROUP];
    end

    // Register the folded summary.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= grp_or;
    end

    assign sum_o = sum_q;
    assign any_o = |sum_q;

    AST_IDLE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> (sum_o == '0)); // R1
endmodule

// File: rtl/gpio_sum_regs.sv
// Module: register window. Two read-only status words show the summary
// zero-extended to 64 bits; the master word holds the global enable and a
// self-clearing end-of-interrupt bit. Assumes SUM_BITS <= 2*REG_W.
module gpio_sum_regs
    import gpio_sum_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int SUM_BITS = 46
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [1:0]          addr_i,
    input  logic [REG_W-1:0]    wdata_i,
    input  logic [SUM_BITS-1:0] sum_i,
    output logic [REG_W-1:0]    rdata_o,
    output logic                en_o,
    output logic                eoi_o
);
    localparam int STAT_W = 2 * REG_W;

    logic [STAT_W-1:0] sum_ext;
    logic              en_q;
    logic              mst_wr;

    // Zero-extend the summary to the full two-word status value.
    always_comb begin
        sum_ext = '0;
        sum_ext[SUM_BITS-1:0] = sum_i;
    end

    assign mst_wr = wr_i && (addr_i == ADDR_MASTER);

    // Hold the global enable; only the master address writes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (mst_wr) en_q <= wdata_i[MST_EN_BIT];
    end

    // End-of-interrupt is a one-cycle strobe and is never stored.
    assign eoi_o = mst_wr && wdata_i[MST_EOI_BIT];
    assign en_o  = en_q;

    // Read multiplexer.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_SUM_LO: rdata_o = sum_ext[REG_W-1:0];
            ADDR_SUM_HI: rdata_o = sum_ext[STAT_W-1:REG_W];
            ADDR_MASTER: rdata_o[MST_EN_BIT] = en_q;
            default:     rdata_o = '0;
        endcase
    end

    AST_HIGH_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_SUM_HI) |-> ((rdata_o >> (SUM_BITS - REG_W)) == '0)); // R3
    AST_EOI_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_MASTER) |-> (rdata_o[MST_EOI_BIT] == 1'b0)); // R5
endmodule

// File: rtl/gpio_sum_irq.sv
// Module: sticky interrupt request. Set when any summary bit is set while
// enabled, held until an end-of-interrupt strobe, dropped when disabled.
// The strobe has priority over a new set in the same cycle.
module gpio_sum_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic eoi_i,
    input  logic any_i,
    output logic irq_o
);
    logic req_q;

    // Update the request latch.
    always_ff @(posedge clk) begin
        if (!rst_n)     req_q <= 1'b0;
        else if (eoi_i) req_q <= 1'b0;
        else if (!en_i) req_q <= 1'b0;
        else if (any_i) req_q <= 1'b1;
    end

    assign irq_o = req_q;

    AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |=> !irq_o); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !eoi_i && en_i) |=> irq_o); // R7
    AST_RISE_NEEDS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(any_i)); // R6
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !irq_o); // R9
endmodule

// File: rtl/gpio_irq_summary.sv
// Module: top of the GPIO interrupt summary aggregator. Folds pin pending
// flags into a grouped summary, exposes it through a small register window
// and drives one shared, acknowledge-rearmed interrupt line.
module gpio_irq_summary #(
    parameter int NUM_PINS = 184,
    parameter int GROUP    = 4,
    parameter int REG_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_pend_i,
    input  logic                reg_wr_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [REG_W-1:0]    reg_wdata_i,
    output logic [REG_W-1:0]    reg_rdata_o,
    output logic                irq_o
);
    localparam int SUM_BITS = (NUM_PINS + GROUP - 1) / GROUP;

    logic [SUM_BITS-1:0] sum;
    logic                any_set;
    logic                en;
    logic                eoi;

    gpio_sum_fold #(
        .NUM_PINS (NUM_PINS),
        .GROUP    (GROUP),
        .SUM_BITS (SUM_BITS)
    ) u_fold (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pin_pend_i),
        .sum_o  (sum),
        .any_o  (any_set)
    );

    gpio_sum_regs #(
        .REG_W    (REG_W),
        .SUM_BITS (SUM_BITS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .sum_i   (sum),
        .rdata_o (reg_rdata_o),
        .en_o    (en),
        .eoi_o   (eoi)
    );

    gpio_sum_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en),
        .eoi_i (eoi),
        .any_i (any_set),
        .irq_o (irq_o)
    );
endmodule

// File: tb/gpio_irq_summary_bench.sv
// Scoreboard bench: driver tasks queue expected items at a falling edge, and a
// monitor pops and compares them shortly after that edge.
module gpio_irq_summary_bench;
    localparam int NP = 184;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pend = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_irq_summary u_gpio_irq_summary (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_pend_i  (pend),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    // Monitor: compare queued expectations just after each falling edge.
    always begin
        @(negedge clk);
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'd0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic check_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        check_irq(1'b0, "R10 line after reset");
        check_rd(2'd0, 32'h0, "R10 low word after reset");
        check_rd(2'd1, 32'h0, "R10 high word after reset");
        check_rd(2'd2, 32'h0, "R10 master after reset");

        wr(2'd2, 32'h1);
        check_rd(2'd2, 32'h1, "R5 enable reads back");
        wr(2'd2, 32'h3);
        check_rd(2'd2, 32'h1, "R5 eoi bit reads 0");

        pend[5] = 1'b1; pend[183] = 1'b1;
        check_irq(1'b0, "R6 no rise same cycle");
        tick();
        check_irq(1'b0, "R6 no rise after one clock");
        check_rd(2'd0, 32'h2, "R1 pin5 -> bit1");
        check_irq(1'b1, "R6 rise after two clocks");
        check_rd(2'd1, 32'h2000, "R2 bit45 at high word bit13");

        pend = '0;
        repeat (3) tick();
        check_irq(1'b1, "R7 sticky after pending clears");
        check_rd(2'd0, 32'h0, "R1 summary clears");

        wr(2'd2, 32'h3);
        check_irq(1'b0, "R8 eoi drops line");
        repeat (2) tick();
        check_irq(1'b0, "R8 stays low with nothing pending");

        pend = '0; pend[40] = 1'b1; tick();
        check_rd(2'd0, 32'h1 << 10, "R1 pin40 -> bit10");
        pend = '0; pend[43] = 1'b1; tick();
        check_rd(2'd0, 32'h1 << 10, "R1 pin43 -> bit10");
        pend = '0; pend[44] = 1'b1; tick();
        check_rd(2'd0, 32'h1 << 11, "R1 pin44 -> bit11");
        pend = '0; pend[3:0] = 4'hF; tick();
        check_rd(2'd0, 32'h1, "R1 pins0-3 -> bit0 only");
        pend = '0; pend[44] = 1'b1;
        repeat (2) tick();
        wr(2'd2, 32'h3);
        check_irq(1'b0, "R8 drop with pin still pending");
        tick();
        check_irq(1'b1, "R8 reassert next clock");

        pend = '0;
        repeat (2) tick();
        wr(2'd2, 32'h3);
        check_irq(1'b0, "R8 cleared before concurrent case");
        pend[100] = 1'b1;
        wr(2'd2, 32'h3);
        check_irq(1'b0, "R8 eoi wins over same-cycle arrival");
        tick();
        check_irq(1'b1, "R6 arrival rearms after eoi");
        check_rd(2'd0, 32'h1 << 25, "R1 pin100 -> bit25");

        pend = '1;
        tick();
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
        check_rd(2'd0, 32'hFFFF_FFFF, "R4 low word ignores write");
        check_rd(2'd1, 32'h0000_3FFF, "R3 unused high bits zero");
        check_rd(2'd3, 32'h0, "R5 unused address reads 0");

        wr(2'd2, 32'h0);
        tick();
        check_irq(1'b0, "R9 disable drops line");
        repeat (3) tick();
        check_irq(1'b0, "R9 stays low while disabled");
        check_rd(2'd2, 32'h0, "R5 enable cleared");
        wr(2'd2, 32'h3);
        check_irq(1'b0, "R9 low right after re-enable");
        tick();
        check_irq(1'b1, "R9 rises after re-enable");
        tick();
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule